// File: doc/BRIEF.md
# Unaligned Read Data Realigner

This block sits on the requesting side of an AXI4-style read data channel. A responder returns every read beat for the bus-aligned word, whatever the low bits of the requested start address are, and it never shifts bytes inside a beat. The realigner takes the low bits of the start address and a byte count. It then consumes the aligned beats, throws away the byte lanes that lie below the start offset, and repacks the remaining bytes into a right-justified word stream. The stream carries a per-lane byte-valid mask and a final-word flag.

Bytes left over at the top of one beat are kept in a small holding store and joined to the low lanes of the next beat. After the last wanted byte has been received, the holding store is emptied with one extra word if bytes remain in it. While a request is offered, the block also drives the number of beats the request needs, so that the address side can use it as the burst length. Both the beat input and the word output use valid/ready handshakes. A stalled output holds back further beats.

Top module: `ualign_read_realigner`

## Requirements
- R1: While a request is presented, `req_beats` equals ceil((`req_offset` + `req_bytes`) / 4), where the bus is four byte lanes.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. A request with a byte count of zero is ignored: `req_ready` stays high, `in_ready` stays low and no output word appears.
- R3: Lanes of the first beat below the start offset are discarded. Lane 0 of the first output word holds the byte at the start address.
- R4: Lanes are little-endian. Lane i (bits 8i+7..8i) of output word k holds the byte at start + 4k + i, and lanes not marked valid are zero. Example: offset 1, three bytes, beat 0x44332211 gives the word 0x00443322.
- R5: Every output word before the final one has `out_keep` = 4'b1111. The final word marks exactly the low n - 4(w-1) lanes, where n is the byte count and w is the word count.
- R6: A request yields exactly ceil(n / 4) output words, and `out_last` is high on the final word only.
- R7: Exactly `req_beats` beats are accepted per request. `in_ready` stays low after that, and surplus bytes of the final beat are dropped.
- R8: With offset 0, a count that is a multiple of 4 and no output stall, each beat appears unchanged as an output word with all lanes valid, one cycle after it is accepted.
- R9: While `out_valid` is high and `out_ready` is low, the output word, mask and flag hold steady and `in_ready` is low.
- R10: `req_ready` is high in the cycle after the final word's handshake.
- R11: Out of reset, `out_valid` and `in_ready` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, can take a request |
| req_offset | input | 2 | Low bits of the byte start address |
| req_bytes | input | CNT_W (12) | Number of bytes wanted |
| req_beats | output | CNT_W (12) | Beats the offered request needs |
| in_valid | input | 1 | Aligned read beat present |
| in_ready | output | 1 | Beat accepted this cycle if valid |
| in_data | input | DATA_W (32) | Aligned read beat |
| out_valid | output | 1 | Packed word present |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | DATA_W (32) | Packed, right-justified word |
| out_keep | output | 4 | Byte-valid mask, one bit per lane |
| out_last | output | 1 | Final word of the request |

## Verification
A wrong skip offset or a stale holding count shows up in the first output word of a request, because its low bytes come out shifted or duplicated. The same fault leaves every later word of that request displaced by the same number of bytes. A wrong remaining-byte count shows at the end of the request: `out_last` arrives too early or too late, the final mask is wrong, or `in_ready` is still high after the last beat. A register that ignores backpressure changes `out_data` during a stall, and this is visible in the very next cycle.

// File: rtl/ualign_pkg.sv
package ualign_pkg;

  // Beats needed to cover nbytes starting at lane offset off.
  function automatic int unsigned beats_for(input int unsigned off,
                                            input int unsigned nbytes,
                                            input int unsigned lanes);
    return (off + nbytes + lanes - 1) / lanes;
  endfunction

  // Useful bytes taken from one beat: limited by what the beat offers
  // above the skip offset and by what the request still needs.
  function automatic int unsigned take_for(input int unsigned remaining,
                                           input int unsigned avail);
    return (remaining < avail) ? remaining : avail;
  endfunction

endpackage

// File: rtl/ra_merge.sv
// Joins held bytes (low) with the useful bytes of a beat (above them).
// Bytes at or above the total count are forced to zero.
module ra_merge #(
  parameter int LANES = 4,
  parameter int OFF_W = 2,
  parameter int SUM_W = 4,
  localparam int DATA_W = LANES * 8,
  localparam int COMB_N = 2 * LANES - 1
) (
  input  logic [DATA_W-1:0]   hold_data,
  input  logic [OFF_W-1:0]    hold_cnt,
  input  logic [OFF_W-1:0]    skip,
  input  logic [DATA_W-1:0]   beat,
  input  logic [SUM_W-1:0]    total,
  output logic [COMB_N*8-1:0] comb
);
  for (genvar g = 0; g < COMB_N; g++) begin : g_byte
    logic [7:0] b;
    always_comb begin
      b = 8'h00;
      if (g < int'(hold_cnt)) begin
        if (g < LANES - 1) b = hold_data[(g % LANES)*8 +: 8];
      end else begin
        for (int j = 0; j < LANES; j++) begin
          if (int'(skip) + g - int'(hold_cnt) == j) b = beat[j*8 +: 8];
        end
      end
      if (g >= int'(total)) b = 8'h00;
    end
    assign comb[g*8 +: 8] = b;
  end
endmodule

// File: rtl/ra_ctrl.sv
// Request state: busy flag, first-beat skip, bytes still to collect,
// and the holding store for leftover bytes.
module ra_ctrl #(
  parameter int LANES = 4,
  parameter int OFF_W = 2,
  parameter int CNT_W = 12,
  localparam int DATA_W = LANES * 8,
  localparam int TAKE_W = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [CNT_W-1:0]  req_bytes,
  input  logic              beat_fire,
  input  logic [TAKE_W-1:0] take,
  input  logic              hold_ld,
  input  logic [DATA_W-1:0] hold_nx_data,
  input  logic [OFF_W-1:0]  hold_nx_cnt,
  input  logic              done_fire,
  output logic              busy,
  output logic [OFF_W-1:0]  skip,
  output logic [CNT_W-1:0]  rem_in,
  output logic [DATA_W-1:0] hold_data,
  output logic [OFF_W-1:0]  hold_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      skip      <= '0;
      rem_in    <= '0;
      hold_data <= '0;
      hold_cnt  <= '0;
    end else if (req_fire) begin
      busy      <= 1'b1;
      skip      <= req_off;
      rem_in    <= req_bytes;
      hold_data <= '0;
      hold_cnt  <= '0;
    end else begin
      if (beat_fire) begin
        skip   <= '0;
        rem_in <= rem_in - CNT_W'(take);
      end
      if (hold_ld) begin
        hold_data <= hold_nx_data;
        hold_cnt  <= hold_nx_cnt;
      end
      if (done_fire) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/ra_outreg.sv
// Output word register with valid/ready hold.
module ra_outreg #(
  parameter int LANES = 4,
  localparam int DATA_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [LANES-1:0]  ld_keep,
  input  logic              ld_last,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [LANES-1:0]  out_keep,
  output logic              out_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_keep  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
      out_keep  <= ld_keep;
      out_last  <= ld_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ualign_read_realigner.sv
module ualign_read_realigner #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [CNT_W-1:0]  req_bytes,
  output logic [CNT_W-1:0]  req_beats,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [LANES-1:0]  out_keep,
  output logic              out_last
);
  import ualign_pkg::*;

  localparam int TAKE_W = OFF_W + 1;
  localparam int SUM_W  = OFF_W + 2;
  localparam int COMB_N = 2 * LANES - 1;
  localparam int COMB_W = COMB_N * 8;

  function automatic logic [LANES-1:0] lane_mask(input logic [SUM_W-1:0] n);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  // Named internal events (used by the checker)
  logic              busy;
  logic              req_fire;
  logic              slot_free;
  logic              beat_fire;
  logic              flush_fire;
  logic              done_fire;
  logic              final_in;

  logic [OFF_W-1:0]  skip;
  logic [CNT_W-1:0]  rem_in;
  logic [DATA_W-1:0] hold_data;
  logic [OFF_W-1:0]  hold_cnt;
  logic [TAKE_W-1:0] avail;
  logic [TAKE_W-1:0] take;
  logic [SUM_W-1:0]  total;
  logic [COMB_W-1:0] comb;

  logic              ld;
  logic [DATA_W-1:0] ld_data;
  logic [LANES-1:0]  ld_keep;
  logic              ld_last;
  logic              hold_ld;
  logic [DATA_W-1:0] hold_nx_data;
  logic [OFF_W-1:0]  hold_nx_cnt;

  // R1: burst length for the address side
  assign req_beats = CNT_W'(beats_for(int'(req_offset), int'(req_bytes), LANES));
  // R2: idle only; a zero count never starts a request
  assign req_ready = !busy;
  assign req_fire  = req_valid && req_ready && (req_bytes != '0);

  assign avail = TAKE_W'(LANES) - TAKE_W'(skip);
  assign take  = TAKE_W'(take_for(int'(rem_in), int'(avail)));
  assign total = SUM_W'(hold_cnt) + SUM_W'(take);
  assign final_in = (CNT_W'(take) == rem_in);

  // R7, R9: beats only while bytes remain and the output slot can take a word
  assign slot_free  = !out_valid || out_ready;
  assign in_ready   = busy && (rem_in != '0) && slot_free;
  assign beat_fire  = in_valid && in_ready;
  assign flush_fire = busy && (rem_in == '0) && (hold_cnt != '0) && slot_free;
  assign done_fire  = out_valid && out_ready && out_last;

  ra_ctrl #(.LANES(LANES), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_fire     (req_fire),
    .req_off      (req_offset),
    .req_bytes    (req_bytes),
    .beat_fire    (beat_fire),
    .take         (take),
    .hold_ld      (hold_ld),
    .hold_nx_data (hold_nx_data),
    .hold_nx_cnt  (hold_nx_cnt),
    .done_fire    (done_fire),
    .busy         (busy),
    .skip         (skip),
    .rem_in       (rem_in),
    .hold_data    (hold_data),
    .hold_cnt     (hold_cnt)
  );

  // R3, R4: discard below skip, place useful bytes above held ones
  ra_merge #(.LANES(LANES), .OFF_W(OFF_W), .SUM_W(SUM_W)) u_merge (
    .hold_data (hold_data),
    .hold_cnt  (hold_cnt),
    .skip      (skip),
    .beat      (in_data),
    .total     (total),
    .comb      (comb)
  );

  // Word emission and holding store update (R5, R6, R7)
  always_comb begin
    ld           = 1'b0;
    ld_data      = '0;
    ld_keep      = '0;
    ld_last      = 1'b0;
    hold_ld      = 1'b0;
    hold_nx_data = '0;
    hold_nx_cnt  = '0;
    if (flush_fire) begin
      ld      = 1'b1;
      ld_data = hold_data;
      ld_keep = lane_mask(SUM_W'(hold_cnt));
      ld_last = 1'b1;
      hold_ld = 1'b1;
    end else if (beat_fire) begin
      hold_ld = 1'b1;
      if (total >= SUM_W'(LANES)) begin
        ld           = 1'b1;
        ld_data      = comb[DATA_W-1:0];
        ld_keep      = '1;
        ld_last      = final_in && (total == SUM_W'(LANES));
        hold_nx_data = DATA_W'(comb[COMB_W-1:DATA_W]);
        hold_nx_cnt  = OFF_W'(total - SUM_W'(LANES));
      end else if (final_in) begin
        ld      = 1'b1;
        ld_data = comb[DATA_W-1:0];
        ld_keep = lane_mask(total);
        ld_last = 1'b1;
      end else begin
        hold_nx_data = comb[DATA_W-1:0];
        hold_nx_cnt  = OFF_W'(total);
      end
    end
  end

  ra_outreg #(.LANES(LANES)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ld),
    .ld_data   (ld_data),
    .ld_keep   (ld_keep),
    .ld_last   (ld_last),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_keep  (out_keep),
    .out_last  (out_last)
  );

endmodule

// File: rtl/ualign_read_realigner_chk.sv
module ualign_read_realigner_chk #(
  parameter int LANES = 4,
  parameter int CNT_W = 12,
  localparam int DATA_W = LANES * 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CNT_W-1:0]  req_bytes,
  input logic [CNT_W-1:0]  req_beats,
  input logic              in_ready,
  input logic              beat_fire,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [LANES-1:0]  out_keep,
  input logic              out_last
);
  logic [CNT_W-1:0] seen_beats;
  logic [CNT_W-1:0] want_beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_beats <= '0;
      want_beats <= '0;
    end else if (req_valid && req_ready && req_bytes != '0) begin
      seen_beats <= '0;
      want_beats <= req_beats;
    end else if (beat_fire) begin
      seen_beats <= seen_beats + 1'b1;
    end
  end

  // R5: words before the final one are full
  a_r5_full_words: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> &out_keep);
  // R5: final word mask is a non-empty run of low lanes
  a_r5_final_low_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> out_keep[0] && ((out_keep & (out_keep + 1'b1)) == '0));
  // R9: stalled word holds
  a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_keep) && $stable(out_last));
  // R9: no intake while stalled
  a_r9_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R7: no beat beyond the computed count
  a_r7_no_surplus: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |-> seen_beats < want_beats);
  // R7: all beats consumed before the final word leaves
  a_r7_all_beats: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |-> seen_beats == want_beats);
  // R2: beats only taken while a request is active
  a_r2_busy_only: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !req_ready);
  // R10: idle again right after the final handshake
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> req_ready);
endmodule

bind ualign_read_realigner ualign_read_realigner_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_bytes (req_bytes),
  .req_beats (req_beats),
  .in_ready  (in_ready),
  .beat_fire (beat_fire),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_keep  (out_keep),
  .out_last  (out_last)
);

// File: tb/ualign_read_realigner_bench.sv
`timescale 1ns/100ps
module ualign_read_realigner_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_offset = '0;
  logic [11:0] req_bytes = '0;
  logic [11:0] req_beats;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic [3:0]  out_keep;
  logic        out_last;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  ualign_read_realigner u_ualign_read_realigner (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_offset(req_offset),
    .req_bytes(req_bytes), .req_beats(req_beats),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_keep(out_keep), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input int a);
    return 8'(((a + 1) * 17) ^ (a >> 4));
  endfunction

  function automatic logic [31:0] mem_word(input int b);
    return {mem_byte(b + 3), mem_byte(b + 2), mem_byte(b + 1), mem_byte(b)};
  endfunction

  task automatic run_txn(input int a, input int n, input bit fast);
    logic [7:0]  q[$];
    int          exp_beats, base, sent, cyc, words, k;
    bit          done, prev_stall, pend, aligned;
    logic [31:0] prev_data, pend_data, exp_data;
    logic [3:0]  prev_keep, exp_keep;
    logic        prev_last, exp_last;
    exp_beats = (a % 4 + n + 3) / 4;
    base = a - a % 4;
    aligned = (a % 4 == 0) && (n % 4 == 0);
    for (int i = 0; i < n; i++) q.push_back(mem_byte(a + i));
    @(negedge clk);
    req_valid = 1'b1; req_offset = 2'(a % 4); req_bytes = 12'(n);
    in_valid = 1'b0; out_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R2 request taken when idle", 64'(req_ready), 64'd1);
    chk(req_beats == 12'(exp_beats), "R1 beat count", 64'(req_beats), 64'(exp_beats));
    sent = 0; cyc = 0; words = 0; done = 0; prev_stall = 0; pend = 0;
    prev_data = '0; prev_keep = '0; prev_last = 1'b0; pend_data = '0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      req_valid = 1'b0;
      in_valid  = (sent < exp_beats) && (fast || $urandom_range(3) != 0);
      in_data   = mem_word(base + 4 * sent);
      out_ready = fast || ($urandom_range(2) != 0);
      #1;
      if (pend) begin
        chk(out_valid && out_data == pend_data, "R8 passthrough word",
            64'(out_data), 64'(pend_data));
        pend = 0;
      end
      if (prev_stall)
        chk(out_valid && out_data == prev_data && out_keep == prev_keep && out_last == prev_last,
            "R9 stalled word held", 64'(out_data), 64'(prev_data));
      if (out_valid && !out_ready)
        chk(in_ready == 1'b0, "R9 intake blocked in stall", 64'(in_ready), 64'd0);
      if (sent >= exp_beats && in_ready) chk(1'b0, "R7 in_ready after last beat", 64'd1, 64'd0);
      if (in_valid && in_ready) begin
        if (fast && aligned) begin pend = 1; pend_data = in_data; end
        sent++;
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R6 word beyond request", 64'(words), 64'((n + 3) / 4));
        end else begin
          k = (q.size() < 4) ? q.size() : 4;
          exp_data = '0;
          for (int i = 0; i < k; i++) exp_data[i*8 +: 8] = q.pop_front();
          exp_keep = 4'((1 << k) - 1);
          exp_last = (q.size() == 0);
          if (words == 0)
            chk(out_data[7:0] == mem_byte(a), "R3 first byte at start address",
                64'(out_data[7:0]), 64'(mem_byte(a)));
          chk(out_data == exp_data, "R4 packed word", 64'(out_data), 64'(exp_data));
          chk(out_keep == exp_keep, "R5 byte mask", 64'(out_keep), 64'(exp_keep));
          chk(out_last == exp_last, "R6 last flag", 64'(out_last), 64'(exp_last));
        end
        words++;
        if (out_last) done = 1;
      end
      prev_stall = out_valid && !out_ready;
      prev_data = out_data; prev_keep = out_keep; prev_last = out_last;
      cyc++;
    end
    chk(done, "watchdog transaction hung", 64'(cyc), 64'd0);
    chk(sent == exp_beats, "R7 beats consumed", 64'(sent), 64'(exp_beats));
    chk(words == (n + 3) / 4, "R6 word count", 64'(words), 64'((n + 3) / 4));
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    #1;
    chk(req_ready == 1'b1 && out_valid == 1'b0, "R10 idle after final word",
        64'(req_ready), 64'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b0 && req_ready == 1'b1, "R11 reset state",
        64'({out_valid, in_ready, req_ready}), 64'b001);
    rst_n = 1'b1;
    // R2: zero-count request ignored
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      req_valid = 1'b1; req_offset = 2'd1; req_bytes = 12'd0; in_valid = 1'b1; out_ready = 1'b1;
      #1;
      chk(req_ready == 1'b1 && in_ready == 1'b0 && out_valid == 1'b0, "R2 zero count ignored",
          64'({req_ready, in_ready, out_valid}), 64'b100);
    end
    @(negedge clk);
    req_valid = 1'b0; in_valid = 1'b0;
    run_txn(1, 3, 1'b0);    // one beat, three upper lanes
    run_txn(1, 7, 1'b1);    // two beats, seven bytes
    run_txn(1, 8, 1'b0);    // three beats needed
    run_txn(0, 16, 1'b1);   // R8 aligned passthrough
    run_txn(32, 4, 1'b1);   // R8 single aligned beat
    run_txn(3, 1, 1'b0);    // top lane only
    run_txn(2, 5, 1'b0);
    run_txn(3, 13, 1'b0);
    for (int t = 0; t < 40; t++)
      run_txn(int'($urandom_range(200)), 1 + int'($urandom_range(39)), 1'($urandom_range(1)));
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule